// File: doc/BRIEF.md
# Forward start-point merge engine

This block reduces time-sorted detector strip hits to cluster start points. Hits sit in a circular store made of two halves, each holding one time slice, with address equal to the hit timestamp modulo the store size. An upstream sorter fills the store. Once both halves hold data, it pulses a slice-complete strobe naming the half it has just finished. The engine then works through the opposite half. It takes hits one at a time, lowest address first, using a per-address occupancy bitmap so that empty addresses cost nothing.

For each selected hit the engine probes the addresses after it, up to a fixed look-ahead, for the first occupied entry whose channel lies within a tolerance of the hit's channel. If it finds one, the hit is folded into that later entry. The later entry's amplitude takes the sum of the two amplitudes, and its fold count rises by one plus the count the current hit already carried. The current hit then disappears. If the look-ahead holds no such entry, the hit is emitted on a write port toward a second-level store, at its own address. A look-ahead that runs off the end of a half continues into the head of the other half. Entries there are read and may be updated, but they stay pending until that half is merged in turn. A one-cycle done pulse tells the sorter that the half is free again.

Top module: `mrg_engine`

## Requirements
- R1: After reset, out_we_o and merge_done_o are low and the occupancy bitmap is empty.
- R2: A pulse on sort_done_i with sort_sec_i = s starts a merge of half 1-s (addresses with MSB = 1-s). Only that half's entries are selected, and every out_addr_o emitted lies in it. merge_done_o pulses for exactly one cycle once no occupied address remains in that half.
- R3: Hits are selected in ascending address order. Selection clears the hit's occupancy bit.
- R4: The look-ahead covers offsets 1 to WIN (default 32) after the selected address. The first qualifying entry is taken, even if a later entry in the window matches the channel better. An entry at offset WIN+1 is never considered.
- R5: An entry qualifies when it is occupied and its channel differs from the selected hit's channel by at most CH_TOL (default 1).
- R6: On a fold, the later entry's amplitude becomes the sum of both amplitudes, saturating at 2^AMP_W-1. Its count becomes later count + current count + 1, saturating at 15. Nothing is emitted for the current hit.
- R7: With no qualifying entry, the hit is emitted with its own channel, amplitude and count at its own address. out_we_o is high in the cycle WIN clock edges after the selection edge. A fold at offset k occupies k cycles after selection.
- R8: Look-ahead addresses wrap modulo the full store size (2 x slice depth), so a window near the end of one half reads the head of the other half, including from the last address back to address 0.
- R9: Entries in the other half keep their occupancy bits during a boundary look-ahead. A folded entry there is emitted, with its updated sum and count, when that half is merged.
- R10: A merge of an empty half raises merge_done_o after the second clock edge following the sort_done_i edge, with no output writes.
- R11: The sorter writes hits with count 0 through wr_en_i, wr_addr_i, wr_chan_i and wr_amp_i, and each write sets the address's occupancy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Sorter write strobe |
| wr_addr_i | input | SLICE_AW+1 | Sorter write address (MSB selects the half) |
| wr_chan_i | input | CH_W | Channel of the written hit |
| wr_amp_i | input | AMP_W | Amplitude of the written hit |
| sort_done_i | input | 1 | One-cycle strobe: a half has been filled |
| sort_sec_i | input | 1 | Half that was just filled |
| merge_done_o | output | 1 | One-cycle strobe: merge of the half finished |
| out_we_o | output | 1 | Start-point write strobe |
| out_addr_o | output | SLICE_AW+1 | Start-point address |
| out_chan_o | output | CH_W | Start-point channel |
| out_amp_o | output | AMP_W | Start-point summed amplitude |
| out_cnt_o | output | CNT_W | Start-point fold count |

## Verification
The assertions assume that the sorter raises sort_done_i only while the engine is idle. They also assume it writes nothing while a merge is running, so no write can collide with a fold or a bit clear, and that WIN is less than the slice depth. The stimulus meets these assumptions by waiting for merge_done_o before every new batch of writes and strobe. The scenarios cover chained folds, channel distance just beyond the tolerance, a partner one address past the window, first-match selection and a fold across the store's end back to address 0. They also cover amplitude and count saturation over a long chain, and an empty half. The bench's own timing model predicts every emitted start point and done pulse to the exact cycle.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIND = 2'd1,
    ST_SCAN = 2'd2
  } mrg_state_e;
endpackage

// File: rtl/mrg_lsb_find.sv
module mrg_lsb_find #(
  parameter int W = 64,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest-set-bit search: downward scan so the lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/mrg_hit_ram.sv
module mrg_hit_ram #(
  parameter int CH_W  = 9,
  parameter int AMP_W = 12,
  parameter int CNT_W = 4,
  parameter int SAW   = 6,
  localparam int AW   = SAW + 1,
  localparam int HALF = 1 << SAW,
  localparam int DEPTH = 2 * HALF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CH_W-1:0]  wr_chan_i,
  input  logic [AMP_W-1:0] wr_amp_i,
  input  logic             upd_en_i,
  input  logic [AW-1:0]    upd_addr_i,
  input  logic [CH_W-1:0]  upd_chan_i,
  input  logic [AMP_W-1:0] upd_amp_i,
  input  logic [CNT_W-1:0] upd_cnt_i,
  input  logic             clr_en_i,
  input  logic [AW-1:0]    clr_addr_i,
  input  logic             sec_i,
  output logic [HALF-1:0]  sec_valid_o,
  input  logic [SAW-1:0]   cur_off_i,
  output logic [CH_W-1:0]  cur_chan_o,
  output logic [AMP_W-1:0] cur_amp_o,
  output logic [CNT_W-1:0] cur_cnt_o,
  input  logic [AW-1:0]    prb_addr_i,
  output logic             prb_valid_o,
  output logic [CH_W-1:0]  prb_chan_o,
  output logic [AMP_W-1:0] prb_amp_o,
  output logic [CNT_W-1:0] prb_cnt_o
);
  logic [CH_W-1:0]  ch_q  [DEPTH];
  logic [AMP_W-1:0] amp_q [DEPTH];
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [HALF-1:0]  half_bits [2];
  logic [AW-1:0]    cur_addr;

  always_ff @(posedge clk_i) begin
    if (upd_en_i) begin
      ch_q[upd_addr_i]  <= upd_chan_i;
      amp_q[upd_addr_i] <= upd_amp_i;
      cnt_q[upd_addr_i] <= upd_cnt_i;
    end else if (wr_en_i) begin
      ch_q[wr_addr_i]  <= wr_chan_i;
      amp_q[wr_addr_i] <= wr_amp_i;
      cnt_q[wr_addr_i] <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (wr_en_i)  valid_q[wr_addr_i]  <= 1'b1;
      if (clr_en_i) valid_q[clr_addr_i] <= 1'b0;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_half
    assign half_bits[s] = valid_q[s*HALF +: HALF];
  end

  assign sec_valid_o = half_bits[sec_i];
  assign cur_addr    = {sec_i, cur_off_i};
  assign cur_chan_o  = ch_q[cur_addr];
  assign cur_amp_o   = amp_q[cur_addr];
  assign cur_cnt_o   = cnt_q[cur_addr];
  assign prb_valid_o = valid_q[prb_addr_i];
  assign prb_chan_o  = ch_q[prb_addr_i];
  assign prb_amp_o   = amp_q[prb_addr_i];
  assign prb_cnt_o   = cnt_q[prb_addr_i];

  // R3: a selected entry no longer counts as pending
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i && !wr_en_i |=> !valid_q[$past(clr_addr_i)]);
  // R11: a sorter write marks its address pending
  p_wr_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !clr_en_i |=> valid_q[$past(wr_addr_i)]);
endmodule

// File: rtl/mrg_ctrl.sv
module mrg_ctrl
  import mrg_pkg::*;
#(
  parameter int CH_W   = 9,
  parameter int AMP_W  = 12,
  parameter int CNT_W  = 4,
  parameter int SAW    = 6,
  parameter int WIN    = 32,
  parameter int CH_TOL = 1,
  localparam int AW    = SAW + 1,
  localparam int KW    = $clog2(WIN + 1),
  localparam int CSW   = CNT_W + 2,
  localparam logic [CSW-1:0] CMAX = CSW'((1 << CNT_W) - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sort_done_i,
  input  logic             sort_sec_i,
  input  logic             found_i,
  input  logic [SAW-1:0]   idx_i,
  input  logic [CH_W-1:0]  cur_chan_i,
  input  logic [AMP_W-1:0] cur_amp_i,
  input  logic [CNT_W-1:0] cur_cnt_i,
  input  logic             prb_valid_i,
  input  logic [CH_W-1:0]  prb_chan_i,
  input  logic [AMP_W-1:0] prb_amp_i,
  input  logic [CNT_W-1:0] prb_cnt_i,
  output logic             sec_o,
  output logic [AW-1:0]    prb_addr_o,
  output logic             clr_en_o,
  output logic [AW-1:0]    clr_addr_o,
  output logic             upd_en_o,
  output logic [AW-1:0]    upd_addr_o,
  output logic [CH_W-1:0]  upd_chan_o,
  output logic [AMP_W-1:0] upd_amp_o,
  output logic [CNT_W-1:0] upd_cnt_o,
  output logic             merge_done_o,
  output logic             out_we_o,
  output logic [AW-1:0]    out_addr_o,
  output logic [CH_W-1:0]  out_chan_o,
  output logic [AMP_W-1:0] out_amp_o,
  output logic [CNT_W-1:0] out_cnt_o
);
  mrg_state_e       state_q;
  logic             sec_q;
  logic [SAW-1:0]   off_q;
  logic [CH_W-1:0]  ch_q;
  logic [AMP_W-1:0] amp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [KW-1:0]    k_q;
  logic             done_q;
  logic             owe_q;
  logic [AW-1:0]    oaddr_q;
  logic [CH_W-1:0]  och_q;
  logic [AMP_W-1:0] oamp_q;
  logic [CNT_W-1:0] ocnt_q;

  logic [CH_W-1:0]  chan_diff;
  logic             close;
  logic             hit;
  logic [AMP_W:0]   amp_sum;
  logic [CSW-1:0]   cnt_sum;
  logic             pick;

  assign prb_addr_o = {sec_q, off_q} + AW'(k_q);

  always_comb begin
    chan_diff = (ch_q >= prb_chan_i) ? (ch_q - prb_chan_i) : (prb_chan_i - ch_q);
    close     = chan_diff <= CH_W'(CH_TOL);
    hit       = (state_q == ST_SCAN) && prb_valid_i && close;
    amp_sum   = {1'b0, amp_q} + {1'b0, prb_amp_i};
    cnt_sum   = CSW'(cnt_q) + CSW'(prb_cnt_i) + CSW'(1);
    pick      = (state_q == ST_FIND) && found_i;
  end

  assign clr_en_o   = pick;
  assign clr_addr_o = {sec_q, idx_i};
  assign upd_en_o   = hit;
  assign upd_addr_o = prb_addr_o;
  assign upd_chan_o = prb_chan_i;
  assign upd_amp_o  = amp_sum[AMP_W] ? '1 : amp_sum[AMP_W-1:0];
  assign upd_cnt_o  = (cnt_sum > CMAX) ? CMAX[CNT_W-1:0] : cnt_sum[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sec_q   <= 1'b0;
      off_q   <= '0;
      ch_q    <= '0;
      amp_q   <= '0;
      cnt_q   <= '0;
      k_q     <= '0;
      done_q  <= 1'b0;
      owe_q   <= 1'b0;
      oaddr_q <= '0;
      och_q   <= '0;
      oamp_q  <= '0;
      ocnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      owe_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sort_done_i) begin
            sec_q   <= ~sort_sec_i;
            state_q <= ST_FIND;
          end
        end
        ST_FIND: begin
          if (found_i) begin
            off_q   <= idx_i;
            ch_q    <= cur_chan_i;
            amp_q   <= cur_amp_i;
            cnt_q   <= cur_cnt_i;
            k_q     <= KW'(1);
            state_q <= ST_SCAN;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SCAN: begin
          if (hit) begin
            state_q <= ST_FIND;
          end else if (k_q == KW'(WIN)) begin
            owe_q   <= 1'b1;
            oaddr_q <= {sec_q, off_q};
            och_q   <= ch_q;
            oamp_q  <= amp_q;
            ocnt_q  <= cnt_q;
            state_q <= ST_FIND;
          end else begin
            k_q <= k_q + KW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sec_o        = sec_q;
  assign merge_done_o = done_q;
  assign out_we_o     = owe_q;
  assign out_addr_o   = oaddr_q;
  assign out_chan_o   = och_q;
  assign out_amp_o    = oamp_q;
  assign out_cnt_o    = ocnt_q;

  // R2: done is a single-cycle strobe
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_done_o |=> !merge_done_o);
  // R2: emitted start points belong to the half under merge
  p_out_sec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |-> out_addr_o[SAW] == sec_q);
  // R2: input rule, a new slice is only announced to an idle engine
  p_sort_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sort_done_i |-> state_q == ST_IDLE);
  // R4: the probe never leaves offsets 1..WIN
  p_win_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SCAN |-> (k_q >= KW'(1)) && (k_q <= KW'(WIN)));
  // R6: a fold never shrinks the partner's amplitude or count
  p_fold_grow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_o |-> (upd_amp_o >= prb_amp_i) && (upd_cnt_o >= prb_cnt_i));
  // R7: a start point and a fold never come from the same selection
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_o |=> !out_we_o);
endmodule

// File: rtl/mrg_engine.sv
module mrg_engine #(
  parameter int CH_W     = 9,
  parameter int AMP_W    = 12,
  parameter int CNT_W    = 4,
  parameter int SLICE_AW = 6,
  parameter int WIN      = 32,
  parameter int CH_TOL   = 1,
  localparam int AW      = SLICE_AW + 1,
  localparam int HALF    = 1 << SLICE_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CH_W-1:0]  wr_chan_i,
  input  logic [AMP_W-1:0] wr_amp_i,
  input  logic             sort_done_i,
  input  logic             sort_sec_i,
  output logic             merge_done_o,
  output logic             out_we_o,
  output logic [AW-1:0]    out_addr_o,
  output logic [CH_W-1:0]  out_chan_o,
  output logic [AMP_W-1:0] out_amp_o,
  output logic [CNT_W-1:0] out_cnt_o
);
  logic             sec;
  logic [HALF-1:0]  sec_valid;
  logic             found;
  logic [SLICE_AW-1:0] idx;
  logic [CH_W-1:0]  cur_chan, prb_chan, upd_chan;
  logic [AMP_W-1:0] cur_amp, prb_amp, upd_amp;
  logic [CNT_W-1:0] cur_cnt, prb_cnt, upd_cnt;
  logic             prb_valid, clr_en, upd_en;
  logic [AW-1:0]    prb_addr, clr_addr, upd_addr;

  mrg_hit_ram #(
    .CH_W(CH_W), .AMP_W(AMP_W), .CNT_W(CNT_W), .SAW(SLICE_AW)
  ) u_ram (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_addr_i, .wr_chan_i, .wr_amp_i,
    .upd_en_i(upd_en), .upd_addr_i(upd_addr), .upd_chan_i(upd_chan),
    .upd_amp_i(upd_amp), .upd_cnt_i(upd_cnt),
    .clr_en_i(clr_en), .clr_addr_i(clr_addr),
    .sec_i(sec), .sec_valid_o(sec_valid),
    .cur_off_i(idx), .cur_chan_o(cur_chan), .cur_amp_o(cur_amp), .cur_cnt_o(cur_cnt),
    .prb_addr_i(prb_addr), .prb_valid_o(prb_valid), .prb_chan_o(prb_chan),
    .prb_amp_o(prb_amp), .prb_cnt_o(prb_cnt)
  );

  mrg_lsb_find #(.W(HALF)) u_find (
    .vec_i(sec_valid), .found_o(found), .idx_o(idx)
  );

  mrg_ctrl #(
    .CH_W(CH_W), .AMP_W(AMP_W), .CNT_W(CNT_W), .SAW(SLICE_AW),
    .WIN(WIN), .CH_TOL(CH_TOL)
  ) u_ctrl (
    .clk_i, .rst_ni, .sort_done_i, .sort_sec_i,
    .found_i(found), .idx_i(idx),
    .cur_chan_i(cur_chan), .cur_amp_i(cur_amp), .cur_cnt_i(cur_cnt),
    .prb_valid_i(prb_valid), .prb_chan_i(prb_chan), .prb_amp_i(prb_amp), .prb_cnt_i(prb_cnt),
    .sec_o(sec), .prb_addr_o(prb_addr),
    .clr_en_o(clr_en), .clr_addr_o(clr_addr),
    .upd_en_o(upd_en), .upd_addr_o(upd_addr), .upd_chan_o(upd_chan),
    .upd_amp_o(upd_amp), .upd_cnt_o(upd_cnt),
    .merge_done_o, .out_we_o, .out_addr_o, .out_chan_o, .out_amp_o, .out_cnt_o
  );
endmodule

// File: tb/tb_mrg_engine.sv
module tb_mrg_engine;
  localparam int DEPTH = 128;
  localparam int HALF  = 64;
  localparam int WIN   = 32;
  localparam int TOL   = 1;
  localparam int AMAX  = 4095;
  localparam int CMAX  = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [8:0] wr_chan = '0;
  logic [11:0] wr_amp = '0;
  logic       sort_done = 1'b0;
  logic       sort_sec = 1'b0;
  logic       merge_done, out_we;
  logic [6:0] out_addr;
  logic [8:0] out_chan;
  logic [11:0] out_amp;
  logic [3:0] out_cnt;

  int checks = 0;
  int fails  = 0;

  int m_ch [DEPTH];
  int m_amp[DEPTH];
  int m_cnt[DEPTH];
  bit m_v  [DEPTH];
  int ev_t[$], ev_a[$], ev_ch[$], ev_amp[$], ev_cnt[$];
  int done_t;
  int ob_amp[DEPTH];
  int ob_cnt[DEPTH];

  always #2 clk = ~clk;

  mrg_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_chan_i(wr_chan), .wr_amp_i(wr_amp),
    .sort_done_i(sort_done), .sort_sec_i(sort_sec),
    .merge_done_o(merge_done), .out_we_o(out_we), .out_addr_o(out_addr),
    .out_chan_o(out_chan), .out_amp_o(out_amp), .out_cnt_o(out_cnt)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R11: sorter write, one per cycle, model mirrors it
  task automatic put(int a, int c, int m);
    wr_en = 1'b1; wr_addr = 7'(a); wr_chan = 9'(c); wr_amp = 12'(m);
    @(negedge clk);
    wr_en = 1'b0;
    m_ch[a] = c; m_amp[a] = m; m_cnt[a] = 0; m_v[a] = 1'b1;
  endtask

  // hit-level reference with cycle stamps counted from the strobe edge
  task automatic model_merge(int sec);
    int t = 1;
    ev_t.delete(); ev_a.delete(); ev_ch.delete(); ev_amp.delete(); ev_cnt.delete();
    forever begin
      int cur = -1;
      bit matched = 1'b0;
      for (int i = 0; i < HALF; i++) begin
        if (cur < 0 && m_v[sec*HALF + i]) cur = sec*HALF + i;
      end
      if (cur < 0) begin
        done_t = t;
        break;
      end
      m_v[cur] = 1'b0;
      for (int k = 1; k <= WIN; k++) begin
        int p = (cur + k) % DEPTH;
        int d = m_ch[p] - m_ch[cur];
        if (d < 0) d = -d;
        if (!matched && m_v[p] && d <= TOL) begin
          matched = 1'b1;
          m_amp[p] = (m_amp[p] + m_amp[cur] > AMAX) ? AMAX : m_amp[p] + m_amp[cur];
          m_cnt[p] = (m_cnt[p] + m_cnt[cur] + 1 > CMAX) ? CMAX : m_cnt[p] + m_cnt[cur] + 1;
          t = t + k + 1;
        end
      end
      if (!matched) begin
        ev_t.push_back(t + WIN); ev_a.push_back(cur); ev_ch.push_back(m_ch[cur]);
        ev_amp.push_back(m_amp[cur]); ev_cnt.push_back(m_cnt[cur]);
        t = t + WIN + 1;
      end
    end
  endtask

  task automatic run_merge(int ssec);
    int c = 0;
    model_merge(1 - ssec);
    for (int i = 0; i < DEPTH; i++) begin
      ob_amp[i] = -1; ob_cnt[i] = -1;
    end
    sort_done = 1'b1; sort_sec = ssec[0];
    @(negedge clk);
    sort_done = 1'b0;
    forever begin
      bit exp_we = (ev_t.size() > 0) && (ev_t[0] == c);
      bit exp_dn = (c == done_t);
      if (out_we !== exp_we) begin
        check(1'b0, "R7", "out_we at cycle", int'(out_we), int'(exp_we));
      end else if (exp_we) begin
        check(out_addr == 7'(ev_a[0]) && out_chan == 9'(ev_ch[0]) &&
              out_amp == 12'(ev_amp[0]) && out_cnt == 4'(ev_cnt[0]),
              "R3", "start point amp (R7 fields)", int'(out_amp), ev_amp[0]);
        check(out_addr[6] == 1'(1 - ssec), "R2", "out half", int'(out_addr[6]), 1 - ssec);
        ob_amp[out_addr] = int'(out_amp); ob_cnt[out_addr] = int'(out_cnt);
        void'(ev_t.pop_front()); void'(ev_a.pop_front()); void'(ev_ch.pop_front());
        void'(ev_amp.pop_front()); void'(ev_cnt.pop_front());
      end
      if (merge_done !== exp_dn) check(1'b0, "R2", "merge_done at cycle", c, done_t);
      if (exp_dn) begin
        check(merge_done === 1'b1 && ev_t.size() == 0, "R2", "done with all emitted",
              ev_t.size(), 0);
        @(negedge clk);
        check(merge_done === 1'b0, "R2", "done single cycle", int'(merge_done), 0);
        break;
      end
      if (c > done_t + 2) begin
        check(1'b0, "R2", "merge overran", c, done_t);
        break;
      end
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_ch[i] = 0; m_amp[i] = 0; m_cnt[i] = 0; m_v[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_we === 1'b0, "R1", "out_we after reset", int'(out_we), 0);
    check(merge_done === 1'b0, "R1", "merge_done after reset", int'(merge_done), 0);

    // half 0 slice and half 1 slice
    put(2, 10, 100); put(5, 11, 50); put(9, 12, 20);
    put(12, 40, 30); put(14, 42, 30);
    put(20, 70, 7);  put(53, 70, 8);
    put(25, 100, 5); put(27, 99, 6); put(28, 101, 7);
    put(70, 70, 9);  put(80, 200, 1); put(100, 300, 3); put(120, 5, 40);
    run_merge(1);
    check(ob_amp[9] == 170 && ob_cnt[9] == 2, "R6", "chained fold at 9", ob_amp[9], 170);
    check(ob_amp[2] == -1 && ob_amp[5] == -1, "R6", "folded hits dropped", ob_amp[5], -1);
    check(ob_amp[12] == 30 && ob_amp[14] == 30, "R5", "distance 2 stays apart", ob_amp[14], 30);
    check(ob_amp[20] == 7, "R4", "partner at WIN+1 ignored", ob_amp[20], 7);
    check(ob_amp[27] == 11 && ob_cnt[27] == 1, "R4", "first match taken", ob_amp[27], 11);
    check(ob_amp[28] == 7 && ob_amp[25] == -1, "R4", "later candidate untouched", ob_amp[28], 7);
    check(ob_amp[53] == -1, "R8", "boundary fold into other half", ob_amp[53], -1);

    // refill half 0 head, merge half 1 (wraps 120 -> 3)
    put(3, 6, 60); put(10, 200, 2);
    run_merge(0);
    check(ob_amp[70] == 17 && ob_cnt[70] == 1, "R9", "other-half fold kept", ob_amp[70], 17);
    check(ob_amp[120] == -1, "R8", "wrap past last address", ob_amp[120], -1);
    check(ob_amp[80] == 1 && ob_amp[100] == 3, "R7", "isolated starts", ob_amp[80], 1);

    // long same-channel chain in half 1 for saturation
    for (int i = 0; i < 17; i++) put(64 + i, 50, 300);
    run_merge(1);
    check(ob_amp[3] == 100 && ob_cnt[3] == 1, "R9", "wrapped fold emitted", ob_amp[3], 100);
    check(ob_amp[10] == 2, "R7", "plain start", ob_amp[10], 2);
    run_merge(0);
    check(ob_amp[80] == AMAX, "R6", "amplitude saturates", ob_amp[80], AMAX);
    check(ob_cnt[80] == CMAX, "R6", "count saturates", ob_cnt[80], CMAX);

    // empty half
    run_merge(1);
    check(done_t == 1, "R10", "empty half done timing", done_t, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule